// File: doc/BRIEF.md
# I2C Packet Command Decoder

This block sits between a host-written transmit word FIFO and a byte-level I2C bus engine. The host describes each transfer as a packet of three 32-bit header words, followed by payload words when the transfer is a write. The decoder reads the header words and issues one registered transfer command. The command carries the target address and its mode, the direction, the byte count, the action at the end of the transfer and the option flags. The decoder then unpacks the write payload into a byte stream with a valid/ready handshake.

After issuing a command the decoder accepts no new header until the bus engine reports completion. It recognises three end actions: a stop, a repeated start, or no bus condition at all, which lets the next packet carry on the same bus transaction. A packet that is not marked as I2C is consumed silently and flagged with an error pulse. A not-acknowledge reported by the engine during a write drops the rest of that packet's payload, unless the packet asked to continue past it.

Top module: `i2c_pkt_cmd_decoder`

## Requirements
- R1: Reset state:
  - `cmd_valid`, `hdr_err` and `wr_valid` are low.
  - `tx_ready` is high, so the decoder is waiting for header word 0.
- R2: Command issue and hold-off:
  - `cmd_valid` is a one-cycle pulse in the cycle after the third header word is accepted.
  - From then on `tx_ready` stays low whenever no payload word is still owed, until `bus_done` ends the transfer.
- R3: Address decode:
  - Header word 2 bit 18 selects 10-bit mode (`cmd_ten_bit`=1). In that mode `cmd_addr` is word 2 bits 9:0.
  - Otherwise `cmd_addr` is word 2 bits 7:1, zero-extended. Bit 0 and bits 14:8 are ignored.
- R4: Word 2 flag bits map to outputs as follows:
  - bit 22 → `cmd_high_speed`
  - bit 21 → `cmd_nak_cont`
  - bit 20 → `cmd_start_byte`
  - bit 19 → `cmd_read`
  - bit 17 → `cmd_irq_en`
- R5: `cmd_end` is encoded as 0 = stop, 1 = repeated start, 2 = continue without start or stop:
  - word 2 bit 16 set gives 1, and wins when bit 15 is also set;
  - otherwise bit 15 set gives 2;
  - otherwise 0.
- R6: `cmd_len` equals header word 1 bits 11:0 plus one, giving a range of 1 to 4096. Bits 31:12 of word 1 are ignored.
- R7: Write payload unpacking:
  - The payload is delivered on `wr_byte` as exactly `cmd_len` bytes.
  - Each word is taken least significant byte first.
  - Unused lanes of the last word are never emitted.
  - `wr_byte` holds steady while `wr_valid` is high and `wr_ready` is low.
- R8: A read packet consumes no payload words and emits no bytes. The word that follows its header is the next packet's word 0.
- R9: A packet whose word 0 bit 4 is clear:
  - raises `hdr_err` for one cycle, in the cycle after word 0 is accepted;
  - produces no `cmd_valid`;
  - has its other two header words and, for a write, its payload words consumed without output.
- R10: Not-acknowledge handling on a write packet:
  - With `cmd_nak_cont` clear, a `bus_nak` pulse stops the byte stream from the next cycle. The remaining payload words are then consumed without output.
  - With `cmd_nak_cont` set, the pulse has no effect and every byte is delivered.
- R11: Done and idle behaviour:
  - A transfer ends only on `bus_done`, after which the next header is accepted.
  - `bus_done` and `bus_nak` have no effect while no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit FIFO word available |
| tx_word | input | 32 | Transmit FIFO word |
| tx_ready | output | 1 | Word is taken on this cycle when valid |
| cmd_valid | output | 1 | One-cycle pulse: new transfer command |
| cmd_addr | output | 10 | Target address |
| cmd_ten_bit | output | 1 | 10-bit address mode |
| cmd_read | output | 1 | Transfer direction is read |
| cmd_len | output | 13 | Byte count, 1 to 4096 |
| cmd_end | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| cmd_high_speed | output | 1 | High-speed mode requested |
| cmd_nak_cont | output | 1 | Keep going after a not-acknowledge |
| cmd_start_byte | output | 1 | Send a start byte first |
| cmd_irq_en | output | 1 | Interrupt on completion requested |
| hdr_err | output | 1 | One-cycle pulse: packet not marked as I2C |
| wr_valid | output | 1 | Payload byte available |
| wr_byte | output | 8 | Payload byte |
| wr_ready | input | 1 | Bus engine takes the byte |
| bus_done | input | 1 | Bus engine finished the transfer |
| bus_nak | input | 1 | Bus engine saw a not-acknowledge |

## Verification
The assertions assume three things about the bus engine:
- it pulses `bus_done` only after it has taken every byte it intends to take;
- it never drives `wr_ready` as a function of `wr_valid` within the same cycle;
- it raises `bus_nak` only while a transfer is running.

Outside a transfer, the only stray completion or not-acknowledge pulses are the ones driven deliberately at idle. The engine model in the bench keeps within these rules:
- it waits for each `cmd_valid` before acting;
- it counts delivered bytes against the command length before it pulses `bus_done`;
- it sends at most one `bus_nak` per write packet, always at a byte boundary inside the payload.

The FIFO side is free to stall or present words at any rate.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;

   localparam int HDR_W  = 32;
   localparam int ADDR_W = 10;

   // header bit positions that the bus engine contract depends on
   localparam int B_PROTO  = 4;
   localparam int B_HS     = 22;
   localparam int B_NAKC   = 21;
   localparam int B_SBYTE  = 20;
   localparam int B_RD     = 19;
   localparam int B_TEN    = 18;
   localparam int B_IE     = 17;
   localparam int B_RSTART = 16;
   localparam int B_CONT   = 15;

   typedef enum logic [1:0] {
      END_STOP   = 2'd0,
      END_RSTART = 2'd1,
      END_CONT   = 2'd2
   } end_act_e;

   typedef enum logic [1:0] {
      ST_HDR0,
      ST_HDR1,
      ST_HDR2,
      ST_RUN
   } seq_st_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              ten;
      logic              rd;
      logic              hs;
      logic              nak_cont;
      logic              start_byte;
      logic              irq_en;
      end_act_e          end_act;
   } xfer_cmd_t;

endpackage

// File: rtl/i2c_pkt_hdr_fields.sv
module i2c_pkt_hdr_fields
   import i2c_pkt_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic [HDR_W-1:0] word,
   output logic             proto_ok,
   output logic [LEN_W:0]   len_bytes,
   output xfer_cmd_t        cmd
);

   initial begin : p_param_chk
      assert (LEN_W >= 1 && LEN_W < B_CONT)
         else $error("LEN_W must fit below the flag field");
   end

   logic unused_bits;
   assign unused_bits = ^word;

   always_comb begin
      proto_ok   = word[B_PROTO];
      len_bytes  = {1'b0, word[LEN_W-1:0]} + (LEN_W+1)'(1);
      cmd.ten        = word[B_TEN];
      cmd.rd         = word[B_RD];
      cmd.hs         = word[B_HS];
      cmd.nak_cont   = word[B_NAKC];
      cmd.start_byte = word[B_SBYTE];
      cmd.irq_en     = word[B_IE];
      if (word[B_TEN]) cmd.addr = word[ADDR_W-1:0];
      else             cmd.addr = ADDR_W'(word[7:1]);
      // repeated start takes priority over continue
      if (word[B_RSTART])    cmd.end_act = END_RSTART;
      else if (word[B_CONT]) cmd.end_act = END_CONT;
      else                   cmd.end_act = END_STOP;
   end

endmodule

// File: rtl/i2c_pkt_unpack.sv
module i2c_pkt_unpack #(
   parameter  int WORD_W = 32,
   localparam int BYTES  = WORD_W / 8,
   localparam int CNT_W  = $clog2(BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              flush,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   input  logic              out_ready,
   output logic              empty
);

   localparam int IDX_W = $clog2(BYTES);

   initial begin : p_param_chk
      assert (WORD_W % 8 == 0 && BYTES >= 2 && (BYTES & (BYTES - 1)) == 0)
         else $error("WORD_W must hold a power-of-two number of bytes");
   end

   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  left_q;
   logic [IDX_W-1:0]  idx_q;
   logic [7:0]        lane [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane[g] = word_q[8*g +: 8];
   end

   assign out_valid = (left_q != '0);
   assign empty     = (left_q == '0);
   assign out_byte  = lane[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         left_q <= '0;
         idx_q  <= '0;
      end else if (flush) begin
         left_q <= '0;
      end else if (load) begin
         word_q <= load_word;
         left_q <= load_cnt;
         idx_q  <= '0;
      end else if (out_valid && out_ready) begin
         left_q <= left_q - CNT_W'(1);
         idx_q  <= idx_q + IDX_W'(1);
      end
   end

   AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !flush |=> out_valid && $stable(out_byte))
      else $error("byte changed while stalled"); // R7
   AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      load && !flush |-> empty)
      else $error("word loaded over unsent bytes"); // R7

endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
   import i2c_pkt_pkg::*;
#(
   parameter  int LEN_W = 12,
   parameter  int BYTES = 4,
   localparam int CNT_W = $clog2(BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic             proto_ok,
   input  logic [LEN_W:0]   len_dec,
   input  xfer_cmd_t        cmd_dec,
   output logic             cmd_valid,
   output xfer_cmd_t        cmd_q,
   output logic [LEN_W:0]   cmd_len,
   output logic             hdr_err,
   output logic             ld_en,
   output logic [CNT_W-1:0] ld_cnt,
   output logic             flush,
   input  logic             pk_empty,
   input  logic             pk_valid,
   input  logic             bus_done,
   input  logic             bus_nak
);

   localparam logic [LEN_W:0] BYTES_L = (LEN_W+1)'(BYTES);

   seq_st_e        state_q;
   logic           bad_q, drop_q, done_q, vld_q, err_q;
   logic [LEN_W:0] len_q, left_q, len_out_q;
   logic [CNT_W-1:0] take;
   logic           accept, nak_hit, fin;

   always_comb begin
      tx_ready = (state_q != ST_RUN) || ((left_q != '0) && (drop_q || pk_empty));
      accept   = tx_valid && tx_ready;
      take     = (left_q >= BYTES_L) ? CNT_W'(BYTES) : left_q[CNT_W-1:0];
      nak_hit  = (state_q == ST_RUN) && bus_nak && !bad_q && !cmd_q.rd && !cmd_q.nak_cont;
      ld_en    = accept && (state_q == ST_RUN) && !drop_q;
      ld_cnt   = take;
      flush    = nak_hit;
      fin      = (state_q == ST_RUN) && (done_q || bus_done) && (left_q == '0)
                 && (pk_empty || nak_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_HDR0;
         bad_q     <= 1'b0;
         drop_q    <= 1'b0;
         done_q    <= 1'b0;
         vld_q     <= 1'b0;
         err_q     <= 1'b0;
         len_q     <= '0;
         left_q    <= '0;
         len_out_q <= '0;
         cmd_q     <= '0;
      end else begin
         vld_q <= 1'b0;
         err_q <= 1'b0;
         unique case (state_q)
            ST_HDR0: if (accept) begin
               bad_q   <= !proto_ok;
               err_q   <= !proto_ok;
               state_q <= ST_HDR1;
            end
            ST_HDR1: if (accept) begin
               len_q   <= len_dec;
               state_q <= ST_HDR2;
            end
            ST_HDR2: if (accept) begin
               state_q <= ST_RUN;
               left_q  <= cmd_dec.rd ? '0 : len_q;
               drop_q  <= bad_q;
               done_q  <= bad_q;
               if (!bad_q) begin
                  cmd_q     <= cmd_dec;
                  len_out_q <= len_q;
                  vld_q     <= 1'b1;
               end
            end
            ST_RUN: begin
               if (accept)   left_q <= left_q - (LEN_W+1)'(take);
               if (nak_hit)  drop_q <= 1'b1;
               if (bus_done) done_q <= 1'b1;
               if (fin)      state_q <= ST_HDR0;
            end
            default: state_q <= ST_HDR0;
         endcase
      end
   end

   assign cmd_valid = vld_q;
   assign cmd_len   = len_out_q;
   assign hdr_err   = err_q;

   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q) else $error("command valid longer than a cycle"); // R2
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> len_out_q != '0) else $error("zero length command"); // R6
   AST_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RUN && cmd_q.rd && !bad_q |-> !pk_valid)
      else $error("bytes during read"); // R8
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> !err_q) else $error("error longer than a cycle"); // R9
   AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RUN && drop_q |-> !pk_valid)
      else $error("bytes while dropping"); // R10
   AST_HDR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RUN && !done_q && !bus_done |=> state_q == ST_RUN)
      else $error("transfer ended without done"); // R11

endmodule

// File: rtl/i2c_pkt_cmd_decoder.sv
module i2c_pkt_cmd_decoder
   import i2c_pkt_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_ready,
   output logic              cmd_valid,
   output logic [9:0]        cmd_addr,
   output logic              cmd_ten_bit,
   output logic              cmd_read,
   output logic [LEN_W:0]    cmd_len,
   output logic [1:0]        cmd_end,
   output logic              cmd_high_speed,
   output logic              cmd_nak_cont,
   output logic              cmd_start_byte,
   output logic              cmd_irq_en,
   output logic              hdr_err,
   output logic              wr_valid,
   output logic [7:0]        wr_byte,
   input  logic              wr_ready,
   input  logic              bus_done,
   input  logic              bus_nak
);

   localparam int BYTES = WORD_W / 8;
   localparam int CNT_W = $clog2(BYTES + 1);

   initial begin : p_param_chk
      assert (WORD_W == HDR_W) else $error("header layout needs 32-bit words");
   end

   logic             proto_ok;
   logic [LEN_W:0]   len_dec;
   xfer_cmd_t        cmd_dec, cmd_q;
   logic             ld_en, flush, pk_empty;
   logic [CNT_W-1:0] ld_cnt;

   i2c_pkt_hdr_fields #(.LEN_W(LEN_W)) i_fields (
      .word      (tx_word),
      .proto_ok  (proto_ok),
      .len_bytes (len_dec),
      .cmd       (cmd_dec)
   );

   i2c_pkt_seq #(.LEN_W(LEN_W), .BYTES(BYTES)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .proto_ok  (proto_ok),
      .len_dec   (len_dec),
      .cmd_dec   (cmd_dec),
      .cmd_valid (cmd_valid),
      .cmd_q     (cmd_q),
      .cmd_len   (cmd_len),
      .hdr_err   (hdr_err),
      .ld_en     (ld_en),
      .ld_cnt    (ld_cnt),
      .flush     (flush),
      .pk_empty  (pk_empty),
      .pk_valid  (wr_valid),
      .bus_done  (bus_done),
      .bus_nak   (bus_nak)
   );

   i2c_pkt_unpack #(.WORD_W(WORD_W)) i_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld_en),
      .load_word (tx_word),
      .load_cnt  (ld_cnt),
      .flush     (flush),
      .out_valid (wr_valid),
      .out_byte  (wr_byte),
      .out_ready (wr_ready),
      .empty     (pk_empty)
   );

   assign cmd_addr       = cmd_q.addr;
   assign cmd_ten_bit    = cmd_q.ten;
   assign cmd_read       = cmd_q.rd;
   assign cmd_end        = cmd_q.end_act;
   assign cmd_high_speed = cmd_q.hs;
   assign cmd_nak_cont   = cmd_q.nak_cont;
   assign cmd_start_byte = cmd_q.start_byte;
   assign cmd_irq_en     = cmd_q.irq_en;

endmodule

// File: tb/test_i2c_pkt_cmd_decoder.sv
`timescale 1ns/1ps
module test_i2c_pkt_cmd_decoder;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        tx_valid = 1'b0, tx_ready;
   logic [31:0] tx_word = '0;
   logic        cmd_valid, cmd_ten_bit, cmd_read, cmd_high_speed, cmd_nak_cont;
   logic        cmd_start_byte, cmd_irq_en, hdr_err, wr_valid;
   logic [9:0]  cmd_addr;
   logic [12:0] cmd_len;
   logic [1:0]  cmd_end;
   logic [7:0]  wr_byte;
   logic        wr_ready = 1'b0, bus_done = 1'b0, bus_nak = 1'b0;

   always #2.5 clk = ~clk;

   i2c_pkt_cmd_decoder i_i2c_pkt_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ten_bit(cmd_ten_bit), .cmd_read(cmd_read),
      .cmd_len(cmd_len), .cmd_end(cmd_end), .cmd_high_speed(cmd_high_speed),
      .cmd_nak_cont(cmd_nak_cont), .cmd_start_byte(cmd_start_byte), .cmd_irq_en(cmd_irq_en),
      .hdr_err(hdr_err), .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
      .bus_done(bus_done), .bus_nak(bus_nak)
   );

   typedef struct {
      bit bad, rd, ten, hs, nc, sb, ie, b16, b15;
      bit [9:0] addr;
      int len, nak_at, off;
   } pkt_t;

   logic [31:0] wq[$];
   pkt_t        pk[$];
   logic [7:0]  pay[$];
   int n_chk = 0, n_fail = 0, n_bad = 0, n_good = 0, n_err_seen = 0, n_cmd_seen = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit [1:0] exp_end(input bit b16, input bit b15);
      return b16 ? 2'd1 : (b15 ? 2'd2 : 2'd0);
   endfunction

   function automatic pkt_t mk(input bit bad, input bit rd, input bit ten, input int addr,
                               input int len, input bit [5:0] fl, input int nak_at);
      pkt_t p;
      p.bad = bad; p.rd = rd; p.ten = ten; p.len = len; p.nak_at = nak_at; p.off = 0;
      p.addr = ten ? 10'(addr) : {3'b0, 7'(addr)};
      {p.hs, p.nc, p.sb, p.ie, p.b16, p.b15} = fl;
      return p;
   endfunction

   task automatic add_pkt(input pkt_t p);
      logic [31:0] h0, h1, h2, w;
      logic [7:0]  b;
      h0 = $urandom; h0[31:28] = 4'd0; h0[4] = !p.bad;
      h1 = $urandom; h1[11:0] = 12'(p.len - 1);
      h2 = $urandom;
      h2[22:15] = {p.hs, p.nc, p.sb, p.rd, p.ten, p.ie, p.b16, p.b15};
      if (p.ten) h2[9:0] = p.addr; else h2[7:1] = p.addr[6:0];
      wq.push_back(h0); wq.push_back(h1); wq.push_back(h2);
      p.off = pay.size();
      if (!p.rd) begin
         for (int k = 0; k < (p.len + 3) / 4; k++) begin
            w = $urandom;
            for (int j = 0; j < 4; j++) begin
               if (4*k + j < p.len) begin
                  b = 8'($urandom);
                  w[8*j +: 8] = b;
                  if (!p.bad) pay.push_back(b);
               end
            end
            wq.push_back(w);
         end
      end
      if (p.bad) n_bad++; else begin pk.push_back(p); n_good++; end
   endtask

   always @(negedge clk) begin
      if (rst_n && hdr_err) n_err_seen++;
      if (rst_n && cmd_valid) n_cmd_seen++;
   end

   task automatic feed();
      while (wq.size() > 0) begin
         @(negedge clk);
         if ($urandom % 5 != 0) begin
            tx_valid = 1'b1;
            tx_word  = wq[0];
            if (tx_ready) void'(wq.pop_front());
         end else tx_valid = 1'b0;
      end
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic pulse_done();
      bus_done = 1'b1; @(negedge clk); bus_done = 1'b0;
   endtask

   task automatic engine();
      pkt_t p;
      int   got;
      bit   nak_sent, rdy;
      while (pk.size() > 0) begin
         p = pk.pop_front();
         do @(negedge clk); while (!cmd_valid);
         chk(cmd_addr == p.addr, "R3", "address", cmd_addr, p.addr);
         chk(cmd_ten_bit == p.ten, "R3", "ten-bit mode", cmd_ten_bit, p.ten);
         chk(cmd_read == p.rd, "R4", "read", cmd_read, p.rd);
         chk({cmd_high_speed, cmd_nak_cont, cmd_start_byte, cmd_irq_en} == {p.hs, p.nc, p.sb, p.ie},
             "R4", "flags", {cmd_high_speed, cmd_nak_cont, cmd_start_byte, cmd_irq_en},
             {p.hs, p.nc, p.sb, p.ie});
         chk(cmd_end == exp_end(p.b16, p.b15), "R5", "end action", cmd_end, exp_end(p.b16, p.b15));
         chk(cmd_len == 13'(p.len), "R6", "length", cmd_len, p.len);
         if (p.rd) begin
            repeat (3) begin
               @(negedge clk);
               chk(!wr_valid, "R8", "no bytes on read", wr_valid, 0);
               chk(!tx_ready, "R2", "header held off", tx_ready, 0);
            end
            pulse_done();
         end else begin
            got = 0; nak_sent = 1'b0;
            while (1) begin
               if (!nak_sent && p.nak_at == got) begin
                  bus_nak = 1'b1; wr_ready = 1'b0; nak_sent = 1'b1;
                  @(negedge clk);
                  bus_nak = 1'b0;
                  if (!p.nc) break;
               end
               if (got == p.len) break;
               rdy = ($urandom % 4) != 0;
               wr_ready = rdy;
               if (wr_valid && rdy) begin
                  chk(wr_byte == pay[p.off + got], "R7", "payload byte", wr_byte, pay[p.off + got]);
                  got++;
               end
               @(negedge clk);
            end
            wr_ready = 1'b0;
            if (nak_sent && !p.nc) begin
               repeat (3) begin
                  chk(!wr_valid, "R10", "stream stopped after nak", wr_valid, 0);
                  @(negedge clk);
               end
            end else begin
               if (nak_sent) chk(got == p.len, "R10", "bytes after ignored nak", got, p.len);
               repeat (2) begin
                  @(negedge clk);
                  chk(!wr_valid, "R7", "no extra lanes", wr_valid, 0);
                  chk(!tx_ready, "R2", "header held off", tx_ready, 0);
               end
            end
            pulse_done();
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk(!cmd_valid && !hdr_err && !wr_valid, "R1", "outputs idle",
          {cmd_valid, hdr_err, wr_valid}, 0);
      chk(tx_ready, "R1", "ready for header", tx_ready, 1);
      bus_done = 1'b1; bus_nak = 1'b1;
      @(negedge clk);
      bus_done = 1'b0; bus_nak = 1'b0;
      @(negedge clk);
      chk(tx_ready && !cmd_valid && !wr_valid && !hdr_err, "R11", "idle done/nak ignored",
          {tx_ready, cmd_valid, wr_valid, hdr_err}, 4'b1000);

      add_pkt(mk(0, 0, 0, 'h55, 1, 6'b000000, -1));
      add_pkt(mk(0, 0, 1, 'h3a5, 4, 6'b100010, -1));
      add_pkt(mk(0, 0, 0, 'h12, 5, 6'b010101, -1));
      add_pkt(mk(0, 1, 0, 'h7f, 9, 6'b001111, -1));
      add_pkt(mk(1, 0, 0, 'h21, 9, 6'b000000, -1));
      add_pkt(mk(0, 1, 1, 'h201, 3, 6'b100100, -1));
      add_pkt(mk(1, 1, 1, 'h111, 2, 6'b000001, -1));
      add_pkt(mk(0, 0, 0, 'h40, 4096, 6'b000000, -1));
      add_pkt(mk(0, 0, 0, 'h0b, 13, 6'b000000, 5));
      add_pkt(mk(0, 0, 1, 'h0c0, 10, 6'b010000, 3));
      add_pkt(mk(0, 0, 0, 'h33, 8, 6'b000000, 0));
      for (int i = 0; i < 30; i++) begin
         automatic int ln = 1 + ($urandom % 40);
         automatic int na = (($urandom % 4) == 0) ? int'($urandom % ln) : -1;
         add_pkt(mk(($urandom % 10) == 0, $urandom % 2, $urandom % 2, $urandom % 1024,
                    ln, 6'($urandom), na));
      end

      fork
         feed();
         engine();
      join
      repeat (5) @(negedge clk);
      chk(tx_ready, "R11", "back to header after done", tx_ready, 1);
      chk(n_err_seen == n_bad, "R9", "error pulses", n_err_seen, n_bad);
      chk(n_cmd_seen == n_good, "R9", "commands only for valid packets", n_cmd_seen, n_good);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule